// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block moves received Ethernet frames from a byte stream into memory. Software prepares a ring of two-word descriptors. Each descriptor names one receive buffer and carries an ownership flag. The engine walks the ring in order. For each descriptor it copies frame bytes into the named buffer, packing four bytes into each 32-bit memory word. It then writes a status word with the length and the frame-boundary flags, and finally marks the descriptor as used so that software can take the buffer.

A frame longer than one buffer continues in the next descriptor. When a descriptor is still marked used at the point where it is needed, the data that would have gone into it is thrown away and a one-cycle overflow pulse is raised. Descriptor and buffer traffic share a single synchronous memory port, and read data returns one cycle after the request. The stream input has a ready signal. The engine lowers it while it fetches or writes back a descriptor.

Top module: `rxring_dma`

## Requirements
- R1: Descriptor word 0 (at descriptor address +0) holds the buffer byte address in bits 31:2, a wrap flag in bit 1 and a used flag in bit 0. Frame bytes are written from the buffer address upward, with byte k of a 32-bit word in bits 8k+7:8k.
- R2: Descriptor word 1 (at descriptor address +4) is written as bits 13:0 = bytes held in that buffer, bit 14 = start of frame, bit 15 = end of frame, and bits 31:16 = 0. It is written only after every data word of that buffer.
- R3: In the cycle after the status write, word 0 of the same descriptor is rewritten with its address and wrap bits unchanged and bit 0 set.
- R4: After a descriptor is finished, the next descriptor is the current address plus 8. If the finished descriptor has its wrap flag set, the next descriptor is the ring base instead. Descriptor reads are 8-byte aligned.
- R5: Each buffer holds BUF_BYTES bytes. In a frame that spans several buffers, only the first buffer has the start flag and only the last has the end flag. Every buffer except the last reports BUF_BYTES as its length. A frame of exactly BUF_BYTES bytes fits in one buffer.
- R6: If the descriptor fetched for a new frame already has its used flag set, the whole frame is consumed without any memory write, ovf pulses for one cycle, and the ring position does not advance.
- R7: While rx_en is low, frames arriving between frames are consumed with no memory access, and the ring position is reloaded from ring_base.
- R8: in_ready is low for exactly two cycles before the first byte of an accepted frame is taken, and for exactly four cycles before the first byte of each following buffer. It is high for every other byte of a frame.
- R9: While idle, bytes that do not carry the start marker are consumed and discarded with no memory write.
- R10: If the next descriptor is owned when a frame crosses a buffer boundary, the buffers already filled keep their data, status and used flag. The rest of the frame is dropped, ovf pulses once, and the ring position stays on the owned descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Receive enable |
| ring_base | input | AW | Byte address of the first descriptor |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| in_ready | output | 1 | Stream byte accepted when high with in_valid |
| ovf | output | 1 | One-cycle pulse when frame data is dropped because a descriptor is owned |
| mem_en | output | 1 | Memory access request |
| mem_we | output | 1 | Write when high, read when low |
| mem_addr | output | AW | Byte address of the 32-bit word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read |

## Verification
Frames are driven at several lengths: a single byte, a length that ends in the middle of a word, exactly one buffer, one byte over a buffer, and a length spanning three buffers. Comparing these separates errors in byte-lane packing, in length counting at the buffer boundary, and in placing the start and end flags. Enough frames are sent to pass the wrap descriptor twice, which shows whether the ring returns to its base. Descriptors left marked used (at frame start and at a mid-frame boundary), stray bytes without a start marker, and traffic with receive disabled each show whether the engine drops data without touching memory and where the ring position rests afterwards.

// File: rtl/rxring_dma.sv
module rxring_dma #(
  parameter int AW        = 32,
  parameter int BUF_BYTES = 1536
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_en,
  input  logic [AW-1:0] ring_base,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  input  logic          in_sof,
  input  logic          in_eof,
  output logic          in_ready,
  output logic          ovf,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata
);
  localparam int CW = $clog2(BUF_BYTES);
  localparam int LW = 14;
  localparam logic [CW-1:0] LAST_IDX = CW'(BUF_BYTES - 1);
  localparam logic [AW-1:0] DSTEP = AW'(8);
  localparam logic [AW-1:0] STOFS = AW'(4);

  typedef enum logic [2:0] {S_IDLE, S_RD, S_CHK, S_DATA, S_STAT, S_USED, S_DROP} st_t;

  st_t           st;
  logic [AW-1:0] cur;
  logic [31:0]   w0_q;
  logic [CW-1:0] cnt;
  logic [23:0]   hold;
  logic [LW-1:0] len_q;
  logic          first_q, last_q, more_q, ovf_q;

  wire start = (st == S_IDLE) && rx_en && in_valid && in_sof;
  assign in_ready = (st == S_DATA) || (st == S_DROP) || ((st == S_IDLE) && !(rx_en && in_sof));
  wire take = in_valid && in_ready;
  wire [1:0] lane = cnt[1:0];
  wire full = (cnt == LAST_IDX);
  wire dwrite = (st == S_DATA) && take && (lane == 2'd3 || in_eof || full);
  wire [31:0] lane_byte = {24'd0, in_data} << {lane, 3'b000};
  wire [AW-1:0] buf_a = AW'({w0_q[31:2], 2'b00});
  wire [AW-1:0] word_ofs = AW'({cnt[CW-1:2], 2'b00});

  assign ovf       = ovf_q;
  assign mem_en    = start || dwrite || st == S_RD || st == S_STAT || st == S_USED;
  assign mem_we    = dwrite || st == S_STAT || st == S_USED;
  assign mem_addr  = dwrite ? buf_a + word_ofs : (st == S_STAT ? cur + STOFS : cur);
  assign mem_wdata = (st == S_STAT) ? {16'd0, last_q, first_q, len_q} :
                     (st == S_USED) ? (w0_q | 32'd1) :
                     ({8'd0, hold} | lane_byte);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cur     <= '0;
      w0_q    <= '0;
      cnt     <= '0;
      hold    <= '0;
      len_q   <= '0;
      first_q <= 1'b0;
      last_q  <= 1'b0;
      more_q  <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      ovf_q <= 1'b0;
      case (st)
        S_IDLE: begin
          if (!rx_en) cur <= ring_base;
          if (start) begin
            first_q <= 1'b1;
            st      <= S_CHK;
          end
        end
        S_RD: st <= S_CHK;
        S_CHK: begin
          w0_q <= mem_rdata;
          cnt  <= '0;
          hold <= '0;
          if (mem_rdata[0]) begin
            ovf_q <= 1'b1;
            st    <= S_DROP;
          end else begin
            st <= S_DATA;
          end
        end
        S_DATA: begin
          if (take) begin
            hold <= dwrite ? 24'd0 : (hold | lane_byte[23:0]);
            cnt  <= cnt + 1'b1;
            if (in_eof) begin
              len_q  <= LW'(cnt) + LW'(1);
              last_q <= 1'b1;
              more_q <= 1'b0;
              st     <= S_STAT;
            end else if (full) begin
              len_q  <= LW'(BUF_BYTES);
              last_q <= 1'b0;
              more_q <= 1'b1;
              st     <= S_STAT;
            end
          end
        end
        S_STAT: st <= S_USED;
        S_USED: begin
          cur     <= w0_q[1] ? ring_base : cur + DSTEP;
          first_q <= 1'b0;
          st      <= more_q ? S_RD : S_IDLE;
        end
        S_DROP: if (take && in_eof) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rxring_dma_chk.sv
module rxring_dma_chk #(
  parameter int AW        = 32,
  parameter int BUF_BYTES = 1536
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_en,
  input logic          in_ready,
  input logic          ovf,
  input logic          mem_en,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [31:0]   mem_wdata,
  input logic [2:0]    st
);
  localparam logic [2:0]  C_IDLE = 3'd0;
  localparam logic [2:0]  C_STAT = 3'd4;
  localparam logic [13:0] BLEN   = 14'(BUF_BYTES);

  p_stat_fmt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_STAT) |-> (mem_en && mem_we && mem_addr[2] && mem_wdata[31:16] == 16'd0 &&
                        mem_wdata[13:0] != 14'd0 && mem_wdata[13:0] <= BLEN));

  p_used_after_stat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_STAT) |=> (mem_en && mem_we && mem_wdata[0] && mem_addr == $past(mem_addr) - AW'(4)));

  p_read_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !mem_we) |-> (mem_addr[2:0] == 3'd0));

  p_mid_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_STAT && mem_wdata[15:14] == 2'b00) |-> (mem_wdata[13:0] == BLEN));

  p_first_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_STAT && mem_wdata[15:14] == 2'b01) |-> (mem_wdata[13:0] == BLEN));

  p_drop_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> !mem_en);

  p_idle_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && st == C_IDLE) |-> !mem_en);

  p_fetch_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !mem_we) |-> !in_ready);

  p_ovf_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> !ovf);
endmodule

bind rxring_dma rxring_dma_chk #(.AW(AW), .BUF_BYTES(BUF_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .in_ready(in_ready), .ovf(ovf),
  .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .st(st)
);

// File: tb/rxring_dma_tb_top.sv
`timescale 1ns/1ps
module rxring_dma_tb_top;
  localparam int AW = 32;
  localparam int BUFB = 16;
  localparam int NDESC = 4;
  localparam logic [31:0] RBASE = 32'h100;
  localparam logic [31:0] BBASE = 32'h200;
  localparam int NVEC = 6;
  localparam logic [15:0] VEC [NVEC] = '{16'h01_10, 16'h07_20, 16'h10_30, 16'h11_40, 16'h21_50, 16'h04_60};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_en = 1'b0;
  logic [AW-1:0] ring_base = RBASE;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0] in_data = 8'd0;
  logic in_ready, ovf, mem_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = 32'd0;
  logic [31:0] mem [0:1023];

  int nchk = 0, nfail = 0, wr_count = 0, ovf_count = 0;

  always #2.5 clk = ~clk;

  rxring_dma #(.AW(AW), .BUF_BYTES(BUFB)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .ring_base(ring_base),
    .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
    .in_ready(in_ready), .ovf(ovf), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) begin
        mem[mem_addr[11:2]] <= mem_wdata;
        wr_count++;
      end else begin
        mem_rdata <= mem[mem_addr[11:2]];
      end
    end
  end

  always @(negedge clk) if (rst_n && ovf) ovf_count++;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] dw0(input int i);
    return (BBASE + 32'(32 * i)) | ((i == NDESC - 1) ? 32'd2 : 32'd0);
  endfunction

  task automatic arm(input int i);
    mem[(RBASE >> 2) + 2 * i]     = dw0(i);
    mem[(RBASE >> 2) + 2 * i + 1] = 32'd0;
  endtask

  task automatic arm_all();
    for (int i = 0; i < NDESC; i++) arm(i);
  endtask

  task automatic own(input int i);
    mem[(RBASE >> 2) + 2 * i] = dw0(i) | 32'd1;
  endtask

  task automatic send(input int len, input logic [7:0] seed, input bit with_sof,
                      output int st0, output int stm);
    st0 = 0;
    stm = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = seed + 8'(i);
      in_sof   = with_sof && (i == 0);
      in_eof   = (i == len - 1);
      #0.5;
      while (!in_ready) begin
        if (i == 0) st0++;
        else if (i == BUFB) stm++;
        @(negedge clk);
        #0.5;
      end
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_sof   = 1'b0;
    in_eof   = 1'b0;
  endtask

  task automatic check_buf(input int idx, input int bl, input bit sof, input bit eof,
                           input logic [7:0] seed, input string req);
    logic [31:0] a0, a1, e1;
    int bad;
    bad = 0;
    e1 = {16'd0, eof, sof, 14'(bl)};
    a1 = mem[(RBASE >> 2) + 2 * idx + 1];
    a0 = mem[(RBASE >> 2) + 2 * idx];
    chk(a1 == e1, {req, " R2 R5 status word"}, a1, e1);
    chk(a0 == (dw0(idx) | 32'd1), {req, " R1 R3 R4 word0 used"}, a0, dw0(idx) | 32'd1);
    for (int j = 0; j < bl; j++) begin
      logic [31:0] ad;
      logic [7:0] got;
      ad  = BBASE + 32'(32 * idx + j);
      got = mem[ad[11:2]][{ad[1:0], 3'b000} +: 8];
      if (got != seed + 8'(j)) bad++;
    end
    chk(bad == 0, {req, " R1 buffer bytes"}, bad, 0);
  endtask

  task automatic check_frame(input int start, input int len, input logic [7:0] seed,
                             input string req, output int nxt);
    int rem, b;
    rem = len;
    b = 0;
    repeat (4) @(negedge clk);
    while (rem > 0) begin
      int bl;
      bl = (rem > BUFB) ? BUFB : rem;
      check_buf((start + b) % NDESC, bl, b == 0, rem <= BUFB, seed + 8'(b * BUFB), req);
      rem -= bl;
      b++;
    end
    nxt = (start + b) % NDESC;
  endtask

  initial begin
    int idx, s0, sm, w, o;
    for (int i = 0; i < 1024; i++) mem[i] = 32'd0;
    arm_all();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R8 reset ready", in_ready, 1);
    chk(ovf == 1'b0, "R6 reset ovf", ovf, 0);
    chk(mem_en == 1'b0, "R7 reset no access", mem_en, 0);

    rx_en = 1'b1;
    @(negedge clk);
    idx = 0;
    for (int v = 0; v < NVEC; v++) begin
      int len;
      logic [7:0] seed;
      len  = int'(VEC[v][15:8]);
      seed = VEC[v][7:0];
      arm_all();
      send(len, seed, 1'b1, s0, sm);
      chk(s0 == 2, "R8 frame start stall", s0, 2);
      if (len > BUFB) chk(sm == 4, "R8 buffer boundary stall", sm, 4);
      check_frame(idx, len, seed, "table", idx);
    end
    chk(idx == 1, "R4 ring position after wrap", idx, 1);
    chk(ovf_count == 0, "R6 no spurious ovf", ovf_count, 0);

    w = wr_count;
    send(5, 8'h77, 1'b0, s0, sm);
    repeat (3) @(negedge clk);
    chk(wr_count == w, "R9 stray bytes not written", wr_count, w);
    chk(s0 == 0, "R9 stray bytes consumed", s0, 0);
    arm_all();
    send(3, 8'h80, 1'b1, s0, sm);
    check_frame(idx, 3, 8'h80, "R9 after stray", idx);

    rx_en = 1'b0;
    repeat (2) @(negedge clk);
    w = wr_count;
    send(8, 8'h90, 1'b1, s0, sm);
    repeat (3) @(negedge clk);
    chk(wr_count == w, "R7 disabled no writes", wr_count, w);
    chk(s0 == 0, "R7 disabled consumed", s0, 0);
    rx_en = 1'b1;
    @(negedge clk);
    arm_all();
    send(3, 8'hA0, 1'b1, s0, sm);
    check_frame(0, 3, 8'hA0, "R7 rewind to base", idx);

    arm_all();
    own(idx);
    w = wr_count;
    o = ovf_count;
    send(10, 8'hB0, 1'b1, s0, sm);
    repeat (3) @(negedge clk);
    chk(wr_count == w, "R6 owned no writes", wr_count, w);
    chk(ovf_count == o + 1, "R6 ovf pulse", ovf_count, o + 1);
    arm_all();
    send(2, 8'hC0, 1'b1, s0, sm);
    check_frame(idx, 2, 8'hC0, "R6 position held", idx);

    arm_all();
    own((idx + 1) % NDESC);
    w = wr_count;
    o = ovf_count;
    send(20, 8'hD0, 1'b1, s0, sm);
    repeat (4) @(negedge clk);
    check_buf(idx, BUFB, 1'b1, 1'b0, 8'hD0, "R10 kept buffer");
    chk(ovf_count == o + 1, "R10 ovf pulse", ovf_count, o + 1);
    chk(wr_count == w + 6, "R10 write count", wr_count, w + 6);
    idx = (idx + 1) % NDESC;
    arm_all();
    send(5, 8'hE0, 1'b1, s0, sm);
    check_frame(idx, 5, 8'hE0, "R10 position on owned", idx);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    nchk++;
    nfail++;
    $display("FAIL watchdog R1 actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule